// File: doc/BRIEF.md
# Priority interrupt router with claim and completion

This block collects level-sensitive interrupt lines from up to `NSRC` peripheral sources and routes them to `NCTX` processor contexts. Every source has its own priority. Every context has its own set of enable bits and its own threshold, and drives one interrupt line. That line is high while at least one source that is enabled for the context and waiting for service has a priority above the context's threshold. Source number 0 is reserved and never exists, so a result of 0 always means "nothing".

Software services an interrupt in two steps, both through one register of its context. A read of that register returns the best candidate and takes it out of the pending set. A write of the same source number later completes it. Between those two steps, a small gateway per source holds the source back, so a line that is still asserted cannot raise a second request. No other action is needed to re-arm the source.

All state is reached through a simple 32-bit word port. A request is presented for one cycle, and read data comes back on the next cycle.

Top module: `irq_router`

## Requirements
- R1: Bit k of `src_level` is source ID k+1. A high level on an idle source (neither pending nor claimed) makes it pending at the next clock edge. A pending source stays pending after its level drops, until it is claimed.
- R2: Each source has a priority word at byte address 4×ID. It holds `PRIO_W` bits (0..15 by default), and higher bits read as zero. Addresses for ID 0 and for IDs above `NSRC` read as zero, and writes to them change nothing.
- R3: The enable bits of context c start at byte address 0x2000 + 0x80×c. Source ID sits in word ID/32, bit ID%32. Bits that belong to no source (including ID 0) read as zero.
- R4: The control area of context c sits at 0x200000 + 0x1000×c. The threshold word is at offset 0x0 (low `PRIO_W` bits kept), and the claim/complete word is at offset 0x4.
- R5: A source may signal a context only if it is pending, it is enabled for that context, and its priority is strictly greater than that context's threshold. A threshold of 15 therefore masks everything, and priority 0 never signals.
- R6: A read of the claim word returns the eligible source with the highest priority, with the lowest ID winning a tie. It returns 0 when no source is eligible. The returned source stops being pending.
- R7: A claimed source cannot become pending again until it is completed, even if its level stays high. A write of its ID to the claim word of a context that has it enabled completes it, and it then re-arms.
- R8: A completion write is ignored if it names an ID that is not currently claimed, or a source that is not enabled for the context being written.
- R9: `rsp_valid` pulses high in the cycle after every read request and only then, with the read data on `rsp_rdata`.
- R10: `ctx_irq` is registered. It reflects the state from one cycle earlier, so it changes one cycle after any change to pending, enable, priority or threshold state. Reset clears priorities, enables, thresholds, pending and claimed state, and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NSRC | Level interrupt lines; bit k is source ID k+1 |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address of the word accessed (word aligned) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| ctx_irq | output | NCTX | One interrupt line per context |

## Verification
The assertions assume that the request port carries at most one access per cycle and that `src_level` changes only between clock edges. They also assume that pending and claimed state move only through the gateway rules, so no source is ever both pending and claimed. The stimulus keeps to word-aligned addresses inside the mapped areas, plus a few deliberate accesses to nonexistent IDs. It changes levels and requests only away from the active edge, and mixes random priority, enable, threshold, claim and completion traffic with directed tie, mask and re-arm cases.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_PRIO = 2'd1,
        RGN_EN   = 2'd2,
        RGN_CTX  = 2'd3
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [9:0] pidx;    // source index inside the priority area
        logic [5:0] ectx;    // context inside the enable area
        logic [4:0] eword;   // word inside a context's enable block
        logic [8:0] cctx;    // context inside the control area
        logic [9:0] creg;    // word inside a context's control block
    } addr_dec_t;

    function automatic addr_dec_t addr_decode(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.pidx  = a[11:2];
        d.ectx  = a[12:7];
        d.eword = a[6:2];
        d.cctx  = a[20:12];
        d.creg  = a[11:2];
        if (a[1:0] != 2'b00)
            d.region = RGN_NONE;
        else if (a[ADDR_W-1:12] == '0)
            d.region = RGN_PRIO;
        else if (a[ADDR_W-1:13] == 11'd1)
            d.region = RGN_EN;
        else if (a[ADDR_W-1:21] == 3'd1)
            d.region = RGN_CTX;
        else
            d.region = RGN_NONE;
        return d;
    endfunction

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic infl_o
);

    typedef struct packed {
        logic pend;
        logic infl;
    } gw_t;

    gw_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        // an idle source latches its level; a claimed one is held back
        g_d.pend = g_q.pend | (level_i & ~g_q.infl);
        if (claim_i) begin
            g_d.pend = 1'b0;
            g_d.infl = 1'b1;
        end else if (done_i) begin
            g_d.infl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign pend_o = g_q.pend;
    assign infl_o = g_q.infl;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             cand_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [ID_W-1:0]           id_o,
    output logic                      hit_o
);

    logic [PRIO_W-1:0] best_p;

    // scan upward; strict compare keeps the lowest ID on a tie and
    // starting from the threshold enforces "strictly above threshold"
    always_comb begin
        best_p = thr_i;
        id_o   = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (cand_i[i] && (prio_i[i] > best_p)) begin
                best_p = prio_i[i];
                id_o   = ID_W'(i);
            end
        end
        hit_o = (id_o != '0);
    end

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NSRC-1:0]                    src_level,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [irq_router_pkg::ADDR_W-1:0]  req_addr,
    input  logic [31:0]                        req_wdata,
    output logic                               rsp_valid,
    output logic [31:0]                        rsp_rdata,
    output logic [NCTX-1:0]                    ctx_irq
);
    import irq_router_pkg::*;

    localparam int ID_W = $clog2(NSRC + 1);

    typedef struct packed {
        logic [NSRC:1][PRIO_W-1:0]   prio;
        logic [NCTX-1:0][NSRC:1]     en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
        logic                        rvalid;
        logic [31:0]                 rdata;
        logic [NCTX-1:0]             irq;
    } st_t;

    st_t s_d, s_q;

    logic [NSRC:1]             pend_vec;
    logic [NSRC:1]             infl_vec;
    logic [NSRC:1]             claim_vec;
    logic [NSRC:1]             done_vec;
    logic [NCTX-1:0][ID_W-1:0] pick_id;
    logic [NCTX-1:0]           pick_hit;
    addr_dec_t                 dec;
    logic [31:0]               rd;

    // one gateway per existing source
    for (genvar i = 1; i <= NSRC; i++) begin : g_gw
        irq_gateway u_gw (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (src_level[i-1]),
            .claim_i (claim_vec[i]),
            .done_i  (done_vec[i]),
            .pend_o  (pend_vec[i]),
            .infl_o  (infl_vec[i])
        );
    end

    // one best-candidate search per context
    for (genvar c = 0; c < NCTX; c++) begin : g_pick
        irq_pick #(
            .NSRC   (NSRC),
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_pick (
            .cand_i (pend_vec & s_q.en[c]),
            .prio_i (s_q.prio),
            .thr_i  (s_q.thr[c]),
            .id_o   (pick_id[c]),
            .hit_o  (pick_hit[c])
        );
    end

    always_comb begin
        s_d       = s_q;
        claim_vec = '0;
        done_vec  = '0;
        rd        = '0;
        dec       = addr_decode(req_addr);
        s_d.irq   = pick_hit;

        if (req_valid) begin
            case (dec.region)
                RGN_PRIO: begin
                    for (int i = 1; i <= NSRC; i++) begin
                        if (int'(dec.pidx) == i) begin
                            if (req_write) s_d.prio[i] = req_wdata[PRIO_W-1:0];
                            else           rd[PRIO_W-1:0] = s_q.prio[i];
                        end
                    end
                end
                RGN_EN: begin
                    for (int c = 0; c < NCTX; c++) begin
                        for (int b = 0; b < 32; b++) begin
                            int id;
                            id = int'(dec.eword) * 32 + b;
                            if (int'(dec.ectx) == c && id >= 1 && id <= NSRC) begin
                                if (req_write) s_d.en[c][id] = req_wdata[b];
                                else           rd[b] = s_q.en[c][id];
                            end
                        end
                    end
                end
                RGN_CTX: begin
                    for (int c = 0; c < NCTX; c++) begin
                        if (int'(dec.cctx) == c) begin
                            if (dec.creg == 10'd0) begin
                                if (req_write) s_d.thr[c] = req_wdata[PRIO_W-1:0];
                                else           rd[PRIO_W-1:0] = s_q.thr[c];
                            end else if (dec.creg == 10'd1) begin
                                if (req_write) begin
                                    for (int i = 1; i <= NSRC; i++)
                                        if (req_wdata == 32'(i))
                                            done_vec[i] = infl_vec[i] & s_q.en[c][i];
                                end else begin
                                    rd = 32'(pick_id[c]);
                                    for (int i = 1; i <= NSRC; i++)
                                        if (pick_hit[c] && int'(pick_id[c]) == i)
                                            claim_vec[i] = 1'b1;
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end

        s_d.rvalid = req_valid & ~req_write;
        s_d.rdata  = rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rvalid;
    assign rsp_rdata = s_q.rdata;
    assign ctx_irq   = s_q.irq;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NSRC = 31,
    parameter int NCTX = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            rsp_valid,
    input logic [NCTX-1:0] ctx_irq,
    input logic [NSRC:1]   pend,
    input logic [NSRC:1]   infl
);

    // R9: a response appears only after a read request
    a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R7: gateway never holds a source both pending and claimed
    a_r7_pend_infl_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & infl) == '0);

    // R7: a claimed source cannot turn pending on the next edge
    a_r7_no_repend: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & $past(infl)) == '0);

    // R6: a pending source leaves the pending set only by being claimed
    a_r6_claim_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend & $past(pend)) & ~infl) == '0);

    // R5: an interrupt line needs some pending source one cycle earlier
    a_r5_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctx_irq) |-> $past(|pend));

    // R10: the first cycle out of reset is quiet
    a_r10_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctx_irq == '0 && !rsp_valid));

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .ctx_irq   (ctx_irq),
    .pend      (pend_vec),
    .infl      (infl_vec)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/100ps
module irq_router_tb;
    localparam int NSRC = 31;
    localparam int NCTX = 2;
    localparam int AW   = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_level = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NCTX-1:0] ctx_irq;

    always #2.5 clk = ~clk;

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ctx_irq(ctx_irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int          mprio [32];
    logic [31:0] men   [NCTX];
    int          mthr  [NCTX];
    logic [31:0] mpend;
    logic [31:0] minfl;
    logic [31:0] exp_rd;

    function automatic int a_prio(int id); return id * 4; endfunction
    function automatic int a_en(int c);    return 'h2000 + 'h80 * c; endfunction
    function automatic int a_thr(int c);   return 'h200000 + 'h1000 * c; endfunction
    function automatic int a_clm(int c);   return 'h200000 + 'h1000 * c + 4; endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // best eligible source for a context, lowest ID on ties
    function automatic int best(int c);
        int bp = mthr[c];
        int b  = 0;
        for (int i = 1; i <= NSRC; i++)
            if (mpend[i] && men[c][i] && mprio[i] > bp) begin
                bp = mprio[i];
                b  = i;
            end
        return b;
    endfunction

    // one clock: apply the requirements to the reference, then compare
    task automatic cycle();
        logic [NCTX-1:0] ei;
        int cl = 0;
        int dn = 0;
        int a;
        for (int c = 0; c < NCTX; c++) ei[c] = (best(c) != 0);
        exp_rd = '0;
        if (req_valid) begin
            a = int'(req_addr);
            if (a < 'h1000) begin
                int id = a / 4;
                if (id >= 1 && id <= NSRC) begin
                    if (req_write) mprio[id] = int'(req_wdata[3:0]);
                    else           exp_rd = 32'(mprio[id]);
                end
            end else if (a >= 'h2000 && a < 'h2000 + 'h80 * NCTX) begin
                int c = (a - 'h2000) / 'h80;
                int w = (a % 'h80) / 4;
                for (int b = 0; b < 32; b++) begin
                    int id = w * 32 + b;
                    if (id >= 1 && id <= NSRC) begin
                        if (req_write) men[c][id] = req_wdata[b];
                        else           exp_rd[b] = men[c][id];
                    end
                end
            end else if (a >= 'h200000 && a < 'h200000 + 'h1000 * NCTX) begin
                int c = (a - 'h200000) / 'h1000;
                int off = a % 'h1000;
                if (off == 0) begin
                    if (req_write) mthr[c] = int'(req_wdata[3:0]);
                    else           exp_rd = 32'(mthr[c]);
                end else if (off == 4) begin
                    if (req_write) begin
                        if (req_wdata >= 1 && req_wdata <= NSRC &&
                            minfl[req_wdata[4:0]] && men[c][req_wdata[4:0]])
                            dn = int'(req_wdata);
                    end else begin
                        cl = best(c);
                        exp_rd = 32'(cl);
                    end
                end
            end
        end
        for (int id = 1; id <= NSRC; id++) begin
            if (id == cl) begin
                mpend[id] = 1'b0;
                minfl[id] = 1'b1;
            end else if (id == dn) begin
                minfl[id] = 1'b0;
            end else if (src_level[id-1] && !minfl[id]) begin
                mpend[id] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk("R10 registered ctx_irq", 32'(ctx_irq), 32'(ei));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic wr(int addr, logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(addr); req_wdata = data;
        cycle();
        chk("R9 no response to write", 32'(rsp_valid), 32'd0);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(int addr, string r);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = AW'(addr); req_wdata = '0;
        cycle();
        chk("R9 read response valid", 32'(rsp_valid), 32'd1);
        chk(r, rsp_rdata, exp_rd);
        req_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 32; i++) mprio[i] = 0;
        for (int c = 0; c < NCTX; c++) begin men[c] = '0; mthr[c] = 0; end
        mpend = '0;
        minfl = '0;

        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 reset ctx_irq", 32'(ctx_irq), 32'd0);
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        rd(a_prio(3), "R10 reset priority");
        rd(a_en(0), "R10 reset enable");

        // R2: priority width and nonexistent IDs
        wr(a_prio(3), 32'hFFFF_FFFF);
        rd(a_prio(3), "R2 upper bits read zero");
        wr(a_prio(0), 32'd5);
        rd(a_prio(0), "R2 ID 0 ignored");
        wr(a_prio(32), 32'd6);
        rd(a_prio(32), "R2 ID beyond range ignored");

        // R3: enable layout
        wr(a_en(0), 32'hFFFF_FFFF);
        rd(a_en(0), "R3 bit 0 reads zero");
        rd(a_en(1), "R3 other context untouched");

        // R4: threshold register
        wr(a_thr(0), 32'h1F);
        rd(a_thr(0), "R4 threshold width");

        // R5: threshold 15 masks, strict compare
        src_level[2] = 1'b1;              // ID 3, priority 15
        idle(3);
        chk("R5 threshold 15 masks", 32'(ctx_irq[0]), 32'd0);
        wr(a_thr(0), 32'd14);
        idle(1);
        chk("R5 priority above threshold", 32'(ctx_irq[0]), 32'd1);
        chk("R3 disabled context quiet", 32'(ctx_irq[1]), 32'd0);

        // R6: ordering and ties
        wr(a_thr(0), 32'd0);
        wr(a_prio(5), 32'd7);
        wr(a_prio(9), 32'd7);
        wr(a_prio(7), 32'd0);
        src_level[4] = 1'b1;
        src_level[8] = 1'b1;
        src_level[6] = 1'b1;
        idle(2);
        rd(a_clm(0), "R6 highest priority first");
        rd(a_clm(0), "R6 tie to lowest ID");
        rd(a_clm(0), "R6 second of tie");
        rd(a_clm(0), "R5 priority 0 never claimed");

        // R7: claimed sources stay blocked
        idle(3);
        rd(a_clm(0), "R7 blocked while claimed");

        // R8: bad completions ignored
        wr(a_clm(0), 32'd12);
        wr(a_clm(1), 32'd5);
        idle(2);
        rd(a_clm(0), "R8 bad completion ignored");

        // R7: completion re-arms
        wr(a_clm(0), 32'd5);
        idle(2);
        rd(a_clm(0), "R7 re-armed after completion");

        // R1: bit mapping and latching of a short pulse
        wr(a_prio(1), 32'd2);
        wr(a_prio(2), 32'd1);
        src_level[0] = 1'b1;
        src_level[1] = 1'b1;
        idle(2);
        src_level[1] = 1'b0;
        idle(2);
        rd(a_clm(0), "R1 bit 0 is ID 1");
        rd(a_clm(0), "R1 pending holds after level drops");

        // random traffic
        for (int it = 0; it < 500; it++) begin
            int op;
            int c;
            if ($urandom_range(3) == 0) src_level = NSRC'($urandom);
            op = int'($urandom_range(7));
            c  = int'($urandom_range(NCTX - 1));
            case (op)
                0: idle(1);
                1: wr(a_prio(int'($urandom_range(33))), $urandom);
                2: wr(a_en(c), $urandom);
                3: wr(a_thr(c), 32'($urandom_range(15)));
                4, 5: rd(a_clm(c), "R6 random claim");
                6: wr(a_clm(c), 32'($urandom_range(33)));
                default: rd(a_prio(int'($urandom_range(31))), "R2 random priority read");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule